// File: doc/BRIEF.md
# Logic Analyzer Trigger Unit

This block decides the moment at which a logic analyzer acquisition triggers. A capture controller pulses `start_i` to open an acquisition. It then presents one channel word per sample together with `sample_en_i`. The unit answers with a single-cycle `trig_o` pulse, and the controller uses that pulse to record the trigger position.

Three modes are available. Immediate mode fires right at the start. Sequential mode watches one selected channel over time and compares its last eight samples against an 8-bit pattern. Parallel mode compares the channel word of each sample against the pattern. In sequential and parallel mode a care mask turns individual bit positions into don't-care. After one trigger the unit stays silent until the next start pulse.

Top module: `la_trig_unit`

## Requirements
- R1: While `rst_n` is low and after its release, `trig_o` is 0 and the unit is disarmed until a start pulse arrives.
- R2: A start pulse with `mode_i` = 0 (immediate) makes `trig_o` high for exactly the one cycle after that edge, without waiting for samples. The trigger position is therefore 0.
- R3: With `mode_i` = 1 (sequential), each enabled sample shifts bit `chan_sel_i` of `sample_i` into a history. `pattern_i` bit k is compared with the sample taken k enabled samples before the newest one. Bit 0 is the newest sample and bit 7 the oldest.
- R4: A `care_i` bit of 0 excludes the matching pattern position from the comparison. A bit of 1 requires equality.
- R5: In sequential mode a match is accepted only if every cared position is already filled with a sample taken since the last start. A full care mask therefore cannot fire before the 8th enabled sample.
- R6: With `mode_i` = 2 (parallel), an enabled sample triggers when `((sample_i ^ pattern_i) & care_i) == 0`, bit i against bit i.
- R7: Each acquisition triggers at most once. After the pulse, `trig_o` stays low until a new start pulse re-arms the unit.
- R8: In sequential and parallel mode, `trig_o` rises only in the cycle after an armed, enabled sample that matches. A cycle without `sample_en_i` never triggers.
- R9: A start pulse takes precedence over a sample in the same cycle. That sample is neither evaluated nor kept, and the start clears the sequential history.
- R10: `mode_i` = 3 is reserved and never triggers.
- R11: An all-zero `care_i` makes sequential or parallel mode trigger on the first enabled sample after start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Opens an acquisition and arms the trigger |
| sample_en_i | input | 1 | Marks a valid channel word on `sample_i` |
| sample_i | input | NCH | Channel word, one bit per channel |
| mode_i | input | 2 | 0 immediate, 1 sequential, 2 parallel, 3 reserved |
| chan_sel_i | input | CSEL_W | Channel index used in sequential mode |
| pattern_i | input | PAT_W | Trigger word |
| care_i | input | PAT_W | Per-bit compare enable |
| trig_o | output | 1 | One-cycle trigger pulse |

## Verification
A wrong history bit, a misplaced shift direction or a fill count that runs ahead all show up as a trigger pulse one sample early or late, or as no pulse at all. The error is visible in the cycle after the offending sample. A stuck armed flag shows as a second pulse within one acquisition, or as a pulse with no start pulse before it. Sweeps over every channel, over many patterns and masks, and over all 256 parallel words compare `trig_o` cycle by cycle against an arithmetic model. Each misbehaviour is therefore caught at the first sample where the model and the design disagree.

// File: rtl/la_trig_pkg.sv
package la_trig_pkg;

  typedef enum logic [1:0] {
    TM_IMM = 2'd0,
    TM_SEQ = 2'd1,
    TM_PAR = 2'd2,
    TM_RSV = 2'd3
  } trig_mode_e;

  // mask with the low n positions set (positions already filled)
  function automatic logic [31:0] filled_mask(input int n);
    if (n >= 32) return '1;
    return (32'd1 << n) - 32'd1;
  endfunction

  // equality on cared bits only
  function automatic logic masked_match(input logic [31:0] a,
                                        input logic [31:0] b,
                                        input logic [31:0] care);
    return ((a ^ b) & care) == 32'd0;
  endfunction

endpackage

// File: rtl/la_trig_seq.sv
module la_trig_seq
  import la_trig_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int PAT_W  = 8,
  parameter int CSEL_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              sample_en_i,
  input  logic [NCH-1:0]    sample_i,
  input  logic [CSEL_W-1:0] chan_sel_i,
  input  logic [PAT_W-1:0]  pattern_i,
  input  logic [PAT_W-1:0]  care_i,
  output logic              seq_hit_o
);
  localparam int FILL_W = $clog2(PAT_W + 1);
  localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(PAT_W);

  logic [PAT_W-1:0]  hist_q, hist_next;
  logic [FILL_W-1:0] fill_q, fill_next;
  logic              chan_bit;
  logic [31:0]       fmask;

  always_comb begin
    chan_bit = 1'b0;
    if (int'(chan_sel_i) < NCH) chan_bit = sample_i[chan_sel_i];
  end

  generate
    if (PAT_W > 1) begin : g_shift
      assign hist_next = {hist_q[PAT_W-2:0], chan_bit};
    end else begin : g_single
      assign hist_next = chan_bit;
    end
  endgenerate

  assign fill_next = (fill_q == FILL_MAX) ? fill_q : fill_q + 1'b1;
  assign fmask     = filled_mask(int'(fill_next));

  always_comb begin
    seq_hit_o = masked_match(32'(hist_next), 32'(pattern_i), 32'(care_i)) &&
                ((32'(care_i) & ~fmask) == 32'd0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || start_i) begin
      hist_q <= '0;
      fill_q <= '0;
    end else if (sample_en_i) begin
      hist_q <= hist_next;
      fill_q <= fill_next;
    end
  end

endmodule

// File: rtl/la_trig_par.sv
module la_trig_par
  import la_trig_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int PAT_W = 8
) (
  input  logic [NCH-1:0]   sample_i,
  input  logic [PAT_W-1:0] pattern_i,
  input  logic [PAT_W-1:0] care_i,
  output logic             par_hit_o
);
  localparam int PW = (NCH < PAT_W) ? NCH : PAT_W;

  assign par_hit_o = masked_match(32'(sample_i[PW-1:0]),
                                  32'(pattern_i[PW-1:0]),
                                  32'(care_i[PW-1:0]));

endmodule

// File: rtl/la_trig_ctrl.sv
module la_trig_ctrl
  import la_trig_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       sample_en_i,
  input  logic [1:0] mode_i,
  input  logic       seq_hit_i,
  input  logic       par_hit_i,
  output logic       armed_o,
  output logic       trig_o
);
  trig_mode_e mode;
  logic       fire;

  assign mode = trig_mode_e'(mode_i);

  always_comb begin
    unique case (mode)
      TM_SEQ:  fire = sample_en_i && seq_hit_i;
      TM_PAR:  fire = sample_en_i && par_hit_i;
      default: fire = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_o <= 1'b0;
      trig_o  <= 1'b0;
    end else if (start_i) begin
      armed_o <= (mode != TM_IMM);
      trig_o  <= (mode == TM_IMM);
    end else if (armed_o && fire) begin
      armed_o <= 1'b0;
      trig_o  <= 1'b1;
    end else begin
      trig_o  <= 1'b0;
    end
  end

endmodule

// File: rtl/la_trig_unit.sv
module la_trig_unit
  import la_trig_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int PAT_W  = 8,
  parameter int CSEL_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              sample_en_i,
  input  logic [NCH-1:0]    sample_i,
  input  logic [1:0]        mode_i,
  input  logic [CSEL_W-1:0] chan_sel_i,
  input  logic [PAT_W-1:0]  pattern_i,
  input  logic [PAT_W-1:0]  care_i,
  output logic              trig_o
);
  logic seq_hit;
  logic par_hit;
  logic armed_q;

  la_trig_seq #(.NCH(NCH), .PAT_W(PAT_W), .CSEL_W(CSEL_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sample_en_i(sample_en_i),
    .sample_i(sample_i), .chan_sel_i(chan_sel_i), .pattern_i(pattern_i),
    .care_i(care_i), .seq_hit_o(seq_hit)
  );

  la_trig_par #(.NCH(NCH), .PAT_W(PAT_W)) par_i (
    .sample_i(sample_i), .pattern_i(pattern_i), .care_i(care_i),
    .par_hit_o(par_hit)
  );

  la_trig_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sample_en_i(sample_en_i),
    .mode_i(mode_i), .seq_hit_i(seq_hit), .par_hit_i(par_hit),
    .armed_o(armed_q), .trig_o(trig_o)
  );

endmodule

// File: rtl/la_trig_chk.sv
module la_trig_chk #(
  parameter int NCH   = 8,
  parameter int PAT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             sample_en_i,
  input logic [NCH-1:0]   sample_i,
  input logic [1:0]       mode_i,
  input logic [PAT_W-1:0] pattern_i,
  input logic [PAT_W-1:0] care_i,
  input logic             armed,
  input logic             trig_o
);
  localparam int PW = (NCH < PAT_W) ? NCH : PAT_W;

  logic par_eq;
  assign par_eq = ((sample_i[PW-1:0] ^ pattern_i[PW-1:0]) & care_i[PW-1:0]) == '0;

  // R1: disarmed and silent right after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> !trig_o && !armed);

  // R2: immediate start gives a pulse in the next cycle
  p_immediate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && mode_i == 2'd0 |=> trig_o);

  // R6: armed parallel match on an enabled sample fires
  p_parallel_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !start_i && sample_en_i && mode_i == 2'd2 && par_eq |=> trig_o);

  // R7: a pulse leaves the unit disarmed and lasts one cycle
  p_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |-> !armed);
  p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o && !start_i |=> !trig_o);

  // R8: no enabled sample, no trigger (unless a start)
  p_need_sample_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i && !sample_en_i |=> !trig_o);
  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !armed && !start_i |=> !trig_o);

  // R10: reserved mode never triggers
  p_reserved_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_i == 2'd3 |=> !trig_o);

  // R11: empty care mask fires on the first enabled sample
  p_zero_care_r11: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !start_i && sample_en_i && care_i == '0 &&
    (mode_i == 2'd1 || mode_i == 2'd2) |=> trig_o);

endmodule

bind la_trig_unit la_trig_chk #(.NCH(NCH), .PAT_W(PAT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .sample_en_i(sample_en_i),
  .sample_i(sample_i), .mode_i(mode_i), .pattern_i(pattern_i),
  .care_i(care_i), .armed(armed_q), .trig_o(trig_o)
);

// File: tb/la_trig_unit_tb.sv
module la_trig_unit_tb_top;
  localparam int NCH = 8;
  localparam int PW  = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic         sample_en_i = 1'b0;
  logic [7:0]   sample_i = '0;
  logic [1:0]   mode_i = '0;
  logic [2:0]   chan_sel_i = '0;
  logic [7:0]   pattern_i = '0;
  logic [7:0]   care_i = '0;
  logic         trig_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // bench model state: m_hist[k] = sample k enabled steps ago
  bit m_armed = 0;
  bit m_hist[8];
  int m_cnt = 0;
  logic [31:0] lfsr = 32'hACE1_2468;

  always #10 clk = ~clk;

  la_trig_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sample_en_i(sample_en_i),
    .sample_i(sample_i), .mode_i(mode_i), .chan_sel_i(chan_sel_i),
    .pattern_i(pattern_i), .care_i(care_i), .trig_o(trig_o)
  );

  function automatic logic [31:0] rnd(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s trig_o=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit model_seq_hit();
    for (int k = 0; k < 8; k++) begin
      if (care_i[k]) begin
        if (k >= m_cnt) return 0;
        if (m_hist[k] != pattern_i[k]) return 0;
      end
    end
    return 1;
  endfunction

  function automatic bit model_par_hit();
    for (int k = 0; k < 8; k++)
      if (care_i[k] && sample_i[k] != pattern_i[k]) return 0;
    return 1;
  endfunction

  // drive one cycle (called at negedge), check trig_o at next negedge
  task automatic cyc(input string req, input bit st, input bit en,
                     input logic [7:0] smp);
    bit exp;
    start_i = st; sample_en_i = en; sample_i = smp;
    exp = 0;
    if (st) begin
      m_armed = (mode_i != 2'd0);
      exp = (mode_i == 2'd0);
      m_cnt = 0;
      for (int k = 0; k < 8; k++) m_hist[k] = 0;
    end else if (en) begin
      for (int k = 7; k > 0; k--) m_hist[k] = m_hist[k-1];
      m_hist[0] = smp[chan_sel_i];
      if (m_cnt < 8) m_cnt++;
      if (m_armed) begin
        if ((mode_i == 2'd1 && model_seq_hit()) ||
            (mode_i == 2'd2 && model_par_hit())) begin
          exp = 1; m_armed = 0;
        end
      end
    end
    @(negedge clk);
    check(req, trig_o, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] s;
    repeat (3) @(negedge clk);
    check("R1", trig_o, 1'b0);
    rst_n = 1'b1;
    cyc("R1", 0, 1, 8'hFF);
    cyc("R1", 0, 1, 8'h00);

    // R2: immediate, sample_en low at start
    mode_i = 2'd0;
    for (int i = 0; i < 3; i++) begin
      cyc("R2", 1, 0, 8'h00);
      cyc("R7", 0, 1, 8'hFF);
      cyc("R7", 0, 1, 8'h00);
    end

    // R3 R5: full care, pattern 0xA5 on channel 5, exact stream (bit7 first)
    mode_i = 2'd1; chan_sel_i = 3'd5; pattern_i = 8'hA5; care_i = 8'hFF;
    cyc("R3", 1, 0, 8'h00);
    for (int i = 7; i >= 0; i--) cyc("R3", 0, 1, {2'b00, pattern_i[i], 5'b0});
    // R7: further identical stream does not retrigger
    for (int i = 7; i >= 0; i--) cyc("R7", 0, 1, {2'b00, pattern_i[i], 5'b0});

    // R5: low-four care, fires after 4 samples
    care_i = 8'h0F; pattern_i = 8'hF6; chan_sel_i = 3'd0;
    cyc("R5", 1, 0, 8'h00);
    for (int i = 3; i >= 0; i--) cyc("R5", 0, 1, {7'b0, pattern_i[i]});

    // R5: all-zero pattern with full care must wait for 8 samples
    pattern_i = 8'h00; care_i = 8'hFF;
    cyc("R5", 1, 0, 8'h00);
    for (int i = 0; i < 9; i++) cyc("R5", 0, 1, 8'h00);

    // R8: gaps in sample_en do not shift or fire
    pattern_i = 8'h81; chan_sel_i = 3'd7;
    cyc("R8", 1, 0, 8'h00);
    for (int i = 7; i >= 0; i--) begin
      cyc("R8", 0, 0, 8'hFF);
      cyc("R8", 0, 1, {pattern_i[i], 7'b0});
    end

    // R9: start with sample in the same cycle; that sample is dropped
    pattern_i = 8'h01; care_i = 8'h01; chan_sel_i = 3'd2;
    cyc("R9", 1, 1, 8'h04);
    cyc("R9", 0, 0, 8'h04);
    cyc("R9", 0, 1, 8'h04);

    // R3 R4: sweep over channels, random patterns, masks and streams
    for (int c = 0; c < 8; c++) begin
      for (int t = 0; t < 12; t++) begin
        chan_sel_i = 3'(c);
        lfsr = rnd(lfsr); pattern_i = lfsr[7:0];
        lfsr = rnd(lfsr); care_i = lfsr[15:8] & lfsr[23:16];
        cyc("R4", 1, 0, 8'h00);
        for (int j = 0; j < 24; j++) begin
          lfsr = rnd(lfsr);
          cyc("R3", 0, lfsr[3:0] != 4'd0, lfsr[15:8]);
        end
      end
    end

    // R6: exhaustive parallel words with full care, one start each
    mode_i = 2'd2; pattern_i = 8'h3C; care_i = 8'hFF;
    for (int v = 0; v < 256; v++) begin
      cyc("R6", 1, 0, 8'h00);
      cyc("R6", 0, 1, 8'(v));
    end
    // R4 R6: random masks over streams
    for (int t = 0; t < 40; t++) begin
      lfsr = rnd(lfsr); pattern_i = lfsr[7:0]; care_i = lfsr[15:8] & lfsr[31:24];
      cyc("R4", 1, 0, 8'h00);
      for (int j = 0; j < 16; j++) begin
        lfsr = rnd(lfsr);
        s = lfsr[7:0] ^ (lfsr[9] ? 8'h00 : lfsr[23:16]);
        cyc("R6", 0, lfsr[12], s);
      end
    end

    // R10: reserved mode never fires
    mode_i = 2'd3; care_i = 8'h00;
    cyc("R10", 1, 0, 8'h00);
    for (int j = 0; j < 6; j++) cyc("R10", 0, 1, 8'(j));

    // R11: empty care fires at the first enabled sample, both modes
    for (int m = 1; m <= 2; m++) begin
      mode_i = 2'(m); care_i = 8'h00; pattern_i = 8'h5A;
      cyc("R11", 1, 0, 8'h00);
      cyc("R11", 0, 0, 8'h00);
      cyc("R11", 0, 1, 8'hC3);
      cyc("R7", 0, 1, 8'h5A);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule